// File: doc/BRIEF.md
# SDRAM Command Injection Multiplexer

This block sits between a small byte-wide host register bus and a two-phase DDR PHY command port. In software mode it lets firmware build raw SDRAM commands (precharge, mode-register load, refresh, activate, read, write) one at a time from registers. Each phase carries its own row/column address, bank and command state. Writing a phase's command register places that command on that phase for a single clock. Read data that the PHY returns is captured into per-phase byte registers, where firmware can read it back.

A select bit in the control register hands the PHY to a hardware memory controller. In that mode every controller signal passes straight through to the PHY, and the controller sees the PHY's read-valid strobes. The clock-enable pin of the memory always follows a control bit, whichever side owns the bus. Reset leaves the memory in software mode with clock-enable low.

The host bus is word indexed. Index 0 holds the control register. Phase p owns a 32-word block that starts at 32*(p+1).

Top module: `sdram_cmd_inject`

## Requirements
- R1: After reset, select and clock-enable are 0, every phase is idle (cs_n, ras_n, cas_n, we_n high and both data enables low), and every register reads back 0.
- R2: The control register is at index 0, with bit 0 selecting the hardware controller and bit 1 as clock-enable. It reads back as written, and bits 7:2 read back as 0.
- R3: phy_cke equals control bit 1 in both software and hardware mode, and it changes on the clock edge that writes the control register.
- R4: Phase offsets 1 and 2 hold the high and low bytes of the 16-bit address, and offset 3 holds the bank. In software mode phy_addr and phy_bank of that phase show these registers, and they read back as written.
- R5: A write to phase offset 0 drives that phase for exactly the next clock cycle. Command bit 0 gives cs, bit 1 gives we, bit 2 gives cas and bit 3 gives ras, each driven active low on the pins. Bit 4 drives write-data enable and bit 5 drives read-data enable, both active high.
- R6: In software mode, every cycle that does not directly follow a command write to a phase is idle on that phase, and a command to one phase leaves the other phase idle.
- R7: Phase offsets 8 to 15 hold write-data byte k at phy_wrdata bits 8k+7:8k of that phase. They are always presented in software mode and read back as written.
- R8: A command with bit 5 set arms its phase. The first read-valid strobe on that phase after arming, in software mode, latches the phase's read data into offsets 16 to 23 (byte k from bits 8k+7:8k). Strobes when the phase is not armed, or in hardware mode, leave the capture unchanged. Host writes to these offsets are ignored.
- R9: With select set, every hardware command, address, bank and data signal appears unchanged on the PHY, and software command writes do not reach it. hw_rddata_valid forwards phy_rddata_valid only while select is set and is 0 otherwise.
- R10: Unmapped indices read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | REG_AW | Host register word index |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Host read byte for reg_addr |
| hw_addr | input | NPHASE*16 | Controller address per phase |
| hw_bank | input | NPHASE*BANK_W | Controller bank per phase |
| hw_cs_n | input | NPHASE | Controller chip select, active low |
| hw_ras_n | input | NPHASE | Controller row strobe, active low |
| hw_cas_n | input | NPHASE | Controller column strobe, active low |
| hw_we_n | input | NPHASE | Controller write enable, active low |
| hw_wrdata_en | input | NPHASE | Controller write-data enable |
| hw_wrdata | input | NPHASE*8*DBYTES | Controller write data |
| hw_rddata_en | input | NPHASE | Controller read-data enable |
| hw_rddata | output | NPHASE*8*DBYTES | Read data forwarded to the controller |
| hw_rddata_valid | output | NPHASE | Read-valid forwarded to the controller |
| phy_addr | output | NPHASE*16 | PHY address per phase |
| phy_bank | output | NPHASE*BANK_W | PHY bank per phase |
| phy_cs_n | output | NPHASE | PHY chip select |
| phy_ras_n | output | NPHASE | PHY row strobe |
| phy_cas_n | output | NPHASE | PHY column strobe |
| phy_we_n | output | NPHASE | PHY write enable |
| phy_cke | output | 1 | Memory clock enable |
| phy_wrdata_en | output | NPHASE | PHY write-data enable |
| phy_wrdata | output | NPHASE*8*DBYTES | PHY write data |
| phy_rddata_en | output | NPHASE | PHY read-data enable |
| phy_rddata | input | NPHASE*8*DBYTES | Read data from the PHY |
| phy_rddata_valid | input | NPHASE | Read-valid strobe from the PHY |

## Verification
If the one-shot flag gets stuck or is lost, it shows on the very cycle after the command write: the command either stays on the phase for a second cycle or never appears. That is why every one of the 64 command codes is swept on each phase and both the pulse cycle and the cycle after it are sampled. A wrong arm flag shows only at the next read-valid strobe, as a capture that should not happen or that is missed. So strobes are applied before arming, after arming, a second time, and in hardware mode. A wrong select or clock-enable state shows at once on the PHY pins and on the forwarded read-valid.

// File: rtl/sdram_inj_pkg.sv
package sdram_inj_pkg;

  // Command register bit positions (decoded by each phase)
  localparam int CMD_CS   = 0;
  localparam int CMD_WE   = 1;
  localparam int CMD_CAS  = 2;
  localparam int CMD_RAS  = 3;
  localparam int CMD_WREN = 4;
  localparam int CMD_RDEN = 5;
  localparam int CMD_W    = 6;

  // Control register bits
  localparam int CTRL_SEL = 0;
  localparam int CTRL_CKE = 1;

  // Word offsets inside one phase block
  localparam int OFF_W = 5;
  localparam logic [OFF_W-1:0] OFF_CMD  = 5'd0;
  localparam logic [OFF_W-1:0] OFF_AHI  = 5'd1;
  localparam logic [OFF_W-1:0] OFF_ALO  = 5'd2;
  localparam logic [OFF_W-1:0] OFF_BANK = 5'd3;
  localparam logic [OFF_W-1:0] OFF_WDAT = 5'd8;
  localparam logic [OFF_W-1:0] OFF_RDAT = 5'd16;

  localparam int ROWADDR_W = 16;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic wren;
    logic rden;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                     we_n: 1'b1, wren: 1'b0, rden: 1'b0};

endpackage

// File: rtl/sdram_inj_rstsync.sv
module sdram_inj_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end

endmodule

// File: rtl/sdram_inj_ctrl.sv
module sdram_inj_ctrl
  import sdram_inj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wdata,
  output logic       sel_hw,
  output logic       cke
);

  logic sel_d, cke_d;

  always_comb begin
    sel_d = sel_hw;
    cke_d = cke;
    if (wr_en) begin
      sel_d = wdata[CTRL_SEL];
      cke_d = wdata[CTRL_CKE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hw <= 1'b0;
      cke    <= 1'b0;
    end else begin
      sel_hw <= sel_d;
      cke    <= cke_d;
    end
  end

  AST_CKE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cke == $past(wdata[CTRL_CKE]))); // R3

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({sel_hw, cke})); // R2

endmodule

// File: rtl/sdram_inj_phase.sv
module sdram_inj_phase
  import sdram_inj_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int DBYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_hw,
  input  logic                   wr_en,
  input  logic [OFF_W-1:0]       off,
  input  logic [7:0]             wdata,
  input  logic [8*DBYTES-1:0]    phy_rddata,
  input  logic                   phy_rdvalid,
  output logic [ROWADDR_W-1:0]   sw_addr,
  output logic [BANK_W-1:0]      sw_bank,
  output cmd_pins_t              sw_cmd,
  output logic [8*DBYTES-1:0]    sw_wrdata,
  output logic [7:0]             rd_byte
);

  localparam int DW = 8 * DBYTES;

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [7:0]        ahi_q, ahi_d, alo_q, alo_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [DW-1:0]     wdat_q, wdat_d, rdat_q, rdat_d;
  logic              fire_q, fire_d, armed_q, armed_d;
  logic              cmd_wr, capture;

  // Next-state logic
  always_comb begin
    cmd_wr  = wr_en && (off == OFF_CMD);
    capture = armed_q && phy_rdvalid && !sel_hw;

    cmd_d   = cmd_wr ? wdata[CMD_W-1:0] : cmd_q;
    ahi_d   = (wr_en && off == OFF_AHI)  ? wdata : ahi_q;
    alo_d   = (wr_en && off == OFF_ALO)  ? wdata : alo_q;
    bank_d  = (wr_en && off == OFF_BANK) ? wdata[BANK_W-1:0] : bank_q;
    fire_d  = cmd_wr;

    armed_d = armed_q;
    if (capture)                     armed_d = 1'b0;
    if (cmd_wr && wdata[CMD_RDEN])   armed_d = 1'b1;

    rdat_d  = capture ? phy_rddata : rdat_q;

    wdat_d  = wdat_q;
    for (int k = 0; k < DBYTES; k++) begin
      if (wr_en && off == OFF_W'(int'(OFF_WDAT) + k))
        wdat_d[8*k +: 8] = wdata;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
      bank_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      fire_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      ahi_q   <= ahi_d;
      alo_q   <= alo_d;
      bank_q  <= bank_d;
      wdat_q  <= wdat_d;
      rdat_q  <= rdat_d;
      fire_q  <= fire_d;
      armed_q <= armed_d;
    end
  end

  // Software-side drive
  assign sw_addr   = {ahi_q, alo_q};
  assign sw_bank   = bank_q;
  assign sw_wrdata = wdat_q;

  always_comb begin
    sw_cmd.cs_n  = !(fire_q && cmd_q[CMD_CS]);
    sw_cmd.ras_n = !(fire_q && cmd_q[CMD_RAS]);
    sw_cmd.cas_n = !(fire_q && cmd_q[CMD_CAS]);
    sw_cmd.we_n  = !(fire_q && cmd_q[CMD_WE]);
    sw_cmd.wren  = fire_q && cmd_q[CMD_WREN];
    sw_cmd.rden  = fire_q && cmd_q[CMD_RDEN];
  end

  // Readback
  always_comb begin
    rd_byte = '0;
    case (off)
      OFF_CMD:  rd_byte = 8'(cmd_q);
      OFF_AHI:  rd_byte = ahi_q;
      OFF_ALO:  rd_byte = alo_q;
      OFF_BANK: rd_byte = 8'(bank_q);
      default:  rd_byte = '0;
    endcase
    for (int k = 0; k < DBYTES; k++) begin
      if (off == OFF_W'(int'(OFF_WDAT) + k)) rd_byte = wdat_q[8*k +: 8];
      if (off == OFF_W'(int'(OFF_RDAT) + k)) rd_byte = rdat_q[8*k +: 8];
    end
  end

  AST_FIRE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_cmd.cs_n |-> $past(cmd_wr)); // R5

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (sw_cmd == CMD_IDLE)); // R6

  AST_CAPTURE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdat_q) |-> $past(armed_q && phy_rdvalid && !sel_hw)); // R8

endmodule

// File: rtl/sdram_inj_mux.sv
module sdram_inj_mux
  import sdram_inj_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int DBYTES = 8
) (
  input  logic                  sel_hw,
  input  logic [ROWADDR_W-1:0]  sw_addr,
  input  logic [BANK_W-1:0]     sw_bank,
  input  cmd_pins_t             sw_cmd,
  input  logic [8*DBYTES-1:0]   sw_wrdata,
  input  logic [ROWADDR_W-1:0]  hw_addr,
  input  logic [BANK_W-1:0]     hw_bank,
  input  cmd_pins_t             hw_cmd,
  input  logic [8*DBYTES-1:0]   hw_wrdata,
  output logic [ROWADDR_W-1:0]  phy_addr,
  output logic [BANK_W-1:0]     phy_bank,
  output cmd_pins_t             phy_cmd,
  output logic [8*DBYTES-1:0]   phy_wrdata
);

  always_comb begin
    if (sel_hw) begin
      phy_addr   = hw_addr;
      phy_bank   = hw_bank;
      phy_cmd    = hw_cmd;
      phy_wrdata = hw_wrdata;
    end else begin
      phy_addr   = sw_addr;
      phy_bank   = sw_bank;
      phy_cmd    = sw_cmd;
      phy_wrdata = sw_wrdata;
    end
  end

endmodule

// File: rtl/sdram_cmd_inject.sv
module sdram_cmd_inject
  import sdram_inj_pkg::*;
#(
  parameter int NPHASE = 2,
  parameter int BANK_W = 3,
  parameter int DBYTES = 8,
  parameter int REG_AW = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [7:0]                   reg_wdata,
  output logic [7:0]                   reg_rdata,
  input  logic [NPHASE*16-1:0]         hw_addr,
  input  logic [NPHASE*BANK_W-1:0]     hw_bank,
  input  logic [NPHASE-1:0]            hw_cs_n,
  input  logic [NPHASE-1:0]            hw_ras_n,
  input  logic [NPHASE-1:0]            hw_cas_n,
  input  logic [NPHASE-1:0]            hw_we_n,
  input  logic [NPHASE-1:0]            hw_wrdata_en,
  input  logic [NPHASE*8*DBYTES-1:0]   hw_wrdata,
  input  logic [NPHASE-1:0]            hw_rddata_en,
  output logic [NPHASE*8*DBYTES-1:0]   hw_rddata,
  output logic [NPHASE-1:0]            hw_rddata_valid,
  output logic [NPHASE*16-1:0]         phy_addr,
  output logic [NPHASE*BANK_W-1:0]     phy_bank,
  output logic [NPHASE-1:0]            phy_cs_n,
  output logic [NPHASE-1:0]            phy_ras_n,
  output logic [NPHASE-1:0]            phy_cas_n,
  output logic [NPHASE-1:0]            phy_we_n,
  output logic                         phy_cke,
  output logic [NPHASE-1:0]            phy_wrdata_en,
  output logic [NPHASE*8*DBYTES-1:0]   phy_wrdata,
  output logic [NPHASE-1:0]            phy_rddata_en,
  input  logic [NPHASE*8*DBYTES-1:0]   phy_rddata,
  input  logic [NPHASE-1:0]            phy_rddata_valid
);

  localparam int DW    = 8 * DBYTES;
  localparam int BLK_W = REG_AW - OFF_W;

  logic              rst_sync_n;
  logic              sel_hw;
  logic              ctrl_wr;
  logic [BLK_W-1:0]  blk;
  logic [OFF_W-1:0]  off;
  logic [NPHASE-1:0] ph_wr;
  logic [7:0]        ph_rd [NPHASE];

  assign blk     = reg_addr[REG_AW-1:OFF_W];
  assign off     = reg_addr[OFF_W-1:0];
  assign ctrl_wr = reg_wr && (blk == '0) && (off == '0);

  sdram_inj_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdram_inj_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (ctrl_wr),
    .wdata  (reg_wdata[1:0]),
    .sel_hw (sel_hw),
    .cke    (phy_cke)
  );

  assign hw_rddata = phy_rddata;

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    logic [ROWADDR_W-1:0] sw_addr, mx_addr;
    logic [BANK_W-1:0]    sw_bank, mx_bank;
    logic [DW-1:0]        sw_wrdata, mx_wrdata;
    cmd_pins_t            sw_cmd, hw_cmd, mx_cmd;

    assign ph_wr[p] = reg_wr && (blk == BLK_W'(p + 1));

    assign hw_cmd = '{cs_n: hw_cs_n[p], ras_n: hw_ras_n[p], cas_n: hw_cas_n[p],
                      we_n: hw_we_n[p], wren: hw_wrdata_en[p], rden: hw_rddata_en[p]};

    sdram_inj_phase #(.BANK_W(BANK_W), .DBYTES(DBYTES)) u_phase (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .sel_hw      (sel_hw),
      .wr_en       (ph_wr[p]),
      .off         (off),
      .wdata       (reg_wdata),
      .phy_rddata  (phy_rddata[p*DW +: DW]),
      .phy_rdvalid (phy_rddata_valid[p]),
      .sw_addr     (sw_addr),
      .sw_bank     (sw_bank),
      .sw_cmd      (sw_cmd),
      .sw_wrdata   (sw_wrdata),
      .rd_byte     (ph_rd[p])
    );

    sdram_inj_mux #(.BANK_W(BANK_W), .DBYTES(DBYTES)) u_mux (
      .sel_hw     (sel_hw),
      .sw_addr    (sw_addr),
      .sw_bank    (sw_bank),
      .sw_cmd     (sw_cmd),
      .sw_wrdata  (sw_wrdata),
      .hw_addr    (hw_addr[p*16 +: 16]),
      .hw_bank    (hw_bank[p*BANK_W +: BANK_W]),
      .hw_cmd     (hw_cmd),
      .hw_wrdata  (hw_wrdata[p*DW +: DW]),
      .phy_addr   (mx_addr),
      .phy_bank   (mx_bank),
      .phy_cmd    (mx_cmd),
      .phy_wrdata (mx_wrdata)
    );

    assign phy_addr[p*16 +: 16]         = mx_addr;
    assign phy_bank[p*BANK_W +: BANK_W] = mx_bank;
    assign phy_wrdata[p*DW +: DW]       = mx_wrdata;
    assign phy_cs_n[p]                  = mx_cmd.cs_n;
    assign phy_ras_n[p]                 = mx_cmd.ras_n;
    assign phy_cas_n[p]                 = mx_cmd.cas_n;
    assign phy_we_n[p]                  = mx_cmd.we_n;
    assign phy_wrdata_en[p]             = mx_cmd.wren;
    assign phy_rddata_en[p]             = mx_cmd.rden;
    assign hw_rddata_valid[p]           = sel_hw && phy_rddata_valid[p];

    AST_SW_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!sel_hw && !$past(ph_wr[p] && off == OFF_CMD)) |->
      (phy_cs_n[p] && phy_ras_n[p] && phy_cas_n[p] && phy_we_n[p] &&
       !phy_wrdata_en[p] && !phy_rddata_en[p])); // R6

    AST_HW_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
      sel_hw |-> (phy_cs_n[p] == hw_cs_n[p] && phy_we_n[p] == hw_we_n[p] &&
                  phy_addr[p*16 +: 16] == hw_addr[p*16 +: 16])); // R9
  end

  // Host readback
  always_comb begin
    reg_rdata = '0;
    if (blk == '0 && off == '0) reg_rdata = {6'b0, phy_cke, sel_hw};
    for (int p = 0; p < NPHASE; p++) begin
      if (blk == BLK_W'(p + 1)) reg_rdata = ph_rd[p];
    end
  end

endmodule

// File: tb/sdram_cmd_inject_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_inject_tb_top;

  localparam int NP = 2;
  localparam int BW = 3;
  localparam int DB = 8;
  localparam int DW = 8 * DB;
  localparam int AW = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [AW-1:0]     reg_addr;
  logic [7:0]        reg_wdata, reg_rdata;
  logic [NP*16-1:0]  hw_addr, phy_addr;
  logic [NP*BW-1:0]  hw_bank, phy_bank;
  logic [NP-1:0]     hw_cs_n, hw_ras_n, hw_cas_n, hw_we_n, hw_wrdata_en, hw_rddata_en;
  logic [NP*DW-1:0]  hw_wrdata, hw_rddata, phy_wrdata, phy_rddata;
  logic [NP-1:0]     hw_rddata_valid, phy_rddata_valid;
  logic [NP-1:0]     phy_cs_n, phy_ras_n, phy_cas_n, phy_we_n, phy_wrdata_en, phy_rddata_en;
  logic              phy_cke;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdram_cmd_inject #(.NPHASE(NP), .BANK_W(BW), .DBYTES(DB), .REG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_addr(hw_addr), .hw_bank(hw_bank), .hw_cs_n(hw_cs_n), .hw_ras_n(hw_ras_n),
    .hw_cas_n(hw_cas_n), .hw_we_n(hw_we_n), .hw_wrdata_en(hw_wrdata_en),
    .hw_wrdata(hw_wrdata), .hw_rddata_en(hw_rddata_en), .hw_rddata(hw_rddata),
    .hw_rddata_valid(hw_rddata_valid), .phy_addr(phy_addr), .phy_bank(phy_bank),
    .phy_cs_n(phy_cs_n), .phy_ras_n(phy_ras_n), .phy_cas_n(phy_cas_n),
    .phy_we_n(phy_we_n), .phy_cke(phy_cke), .phy_wrdata_en(phy_wrdata_en),
    .phy_wrdata(phy_wrdata), .phy_rddata_en(phy_rddata_en), .phy_rddata(phy_rddata),
    .phy_rddata_valid(phy_rddata_valid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = AW'(a);
    reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic rd_capture(input int p, output logic [63:0] v);
    logic [7:0] b;
    v = '0;
    for (int k = 0; k < DB; k++) begin
      rd(32*(p+1) + 16 + k, b);
      v[8*k +: 8] = b;
    end
  endtask

  task automatic strobe(input int p, input logic [63:0] d);
    @(negedge clk);
    phy_rddata[p*DW +: DW] = d;
    phy_rddata_valid[p]    = 1'b1;
    @(negedge clk);
    phy_rddata_valid[p]    = 1'b0;
  endtask

  // {cs_n, we_n, cas_n, ras_n, wren, rden}
  function automatic logic [5:0] obs(input int p);
    return {phy_cs_n[p], phy_we_n[p], phy_cas_n[p], phy_ras_n[p],
            phy_wrdata_en[p], phy_rddata_en[p]};
  endfunction

  function automatic logic [5:0] expect_cmd(input logic [5:0] c);
    return {~c[0], ~c[1], ~c[2], ~c[3], c[4], c[5]};
  endfunction

  localparam logic [5:0] IDLE = 6'b111100;

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [63:0] cap;
    logic [15:0] a;
    logic [63:0] wd;

    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    hw_addr = 32'hbeef_1234; hw_bank = 6'b110_011;
    hw_cs_n = '0; hw_ras_n = '0; hw_cas_n = '0; hw_we_n = '0;
    hw_wrdata_en = '1; hw_rddata_en = '1; hw_wrdata = {NP*DB{8'h5a}};
    phy_rddata = '0; phy_rddata_valid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 cke", phy_cke, 0);
    for (int p = 0; p < NP; p++) chk("R1 idle", obs(p), IDLE);
    chk("R1 wrdata", phy_wrdata, 0);
    rd(0, b); chk("R1 ctrl", b, 0);
    for (int p = 0; p < NP; p++)
      for (int o = 0; o < 24; o++) begin
        rd(32*(p+1) + o, b); chk("R1 phase reg", b, 0);
      end

    // R2, R3, R9: control values
    for (int v = 0; v < 4; v++) begin
      wr(0, v | 8'hfc);
      chk("R3 cke", phy_cke, v[1]);
      rd(0, b); chk("R2 ctrl readback", b, v);
      phy_rddata_valid = '1; #1;
      chk("R9 valid forward", hw_rddata_valid, v[0] ? 2'b11 : 2'b00);
      phy_rddata_valid = '0;
    end
    wr(0, 2);
    chk("R3 cke sw", phy_cke, 1);
    // R9 in sw mode: active hw pins do not reach PHY
    for (int p = 0; p < NP; p++) chk("R9 sw blocks hw", obs(p), IDLE);

    // R4: address and bank
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < 18; i++) begin
        a = (i < 16) ? 16'(1 << i) : (i == 16 ? 16'hffff : 16'ha5c3);
        wr(32*(p+1) + 1, a[15:8]);
        wr(32*(p+1) + 2, a[7:0]);
        wr(32*(p+1) + 3, i % 8);
        chk("R4 addr", phy_addr[p*16 +: 16], a);
        chk("R4 bank", phy_bank[p*BW +: BW], i % 8);
        rd(32*(p+1) + 1, b); chk("R4 hi readback", b, a[15:8]);
        rd(32*(p+1) + 2, b); chk("R4 lo readback", b, a[7:0]);
        rd(32*(p+1) + 3, b); chk("R4 bank readback", b, i % 8);
      end

    // R5, R6: exhaustive command sweep on each phase
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < 64; c++) begin
        wr(32*(p+1), c);
        chk("R5 pulse", obs(p), expect_cmd(6'(c)));
        chk("R6 other phase idle", obs(1 - p), IDLE);
        @(negedge clk);
        chk("R6 after pulse idle", obs(p), IDLE);
        rd(32*(p+1), b); chk("R5 cmd readback", b, c);
      end

    // R7: write data bytes
    for (int p = 0; p < NP; p++) begin
      wd = '0;
      for (int k = 0; k < DB; k++) begin
        wd[8*k +: 8] = 8'(p*16 + k*37 + 8'h11);
        wr(32*(p+1) + 8 + k, wd[8*k +: 8]);
      end
      chk("R7 wrdata presented", phy_wrdata[p*DW +: DW], wd);
      for (int k = 0; k < DB; k++) begin
        rd(32*(p+1) + 8 + k, b); chk("R7 wrdata readback", b, wd[8*k +: 8]);
      end
      wr(32*(p+1), 8'h13);
      chk("R7 wren pulse", {phy_wrdata_en[p], phy_we_n[p]}, 2'b10);
      chk("R7 wrdata at pulse", phy_wrdata[p*DW +: DW], wd);
    end

    // R8: read capture (sweep left both phases armed)
    for (int p = 0; p < NP; p++) begin
      strobe(p, 64'h0102_0304_0506_0708 + 64'(p));
      rd_capture(p, cap); chk("R8 armed capture", cap, 64'h0102_0304_0506_0708 + 64'(p));
      strobe(p, 64'hdead_beef_cafe_f00d);
      rd_capture(p, cap); chk("R8 unarmed ignored", cap, 64'h0102_0304_0506_0708 + 64'(p));
      wr(32*(p+1), 8'h25);
      chk("R8 rden pulse", obs(p), expect_cmd(6'h25));
      strobe(p, 64'h8899_aabb_ccdd_eeff ^ 64'(p));
      rd_capture(p, cap); chk("R8 rearmed capture", cap, 64'h8899_aabb_ccdd_eeff ^ 64'(p));
      strobe(p, 64'h1111_2222_3333_4444);
      rd_capture(p, cap); chk("R8 second strobe ignored", cap, 64'h8899_aabb_ccdd_eeff ^ 64'(p));
      wr(32*(p+1) + 16, 8'h00);
      rd(32*(p+1) + 16, b); chk("R8 capture write ignored", b, 8'hff ^ 8'(p));
    end

    // R9: hardware mode pass-through
    wr(0, 3);
    hw_addr = 32'h1234_abcd; hw_bank = 6'b101_010;
    hw_cs_n = 2'b01; hw_ras_n = 2'b10; hw_cas_n = 2'b11; hw_we_n = 2'b00;
    hw_wrdata_en = 2'b01; hw_rddata_en = 2'b10;
    hw_wrdata = {64'h0f0e_0d0c_0b0a_0908, 64'h7766_5544_3322_1100};
    #1;
    chk("R9 addr", phy_addr, hw_addr);
    chk("R9 bank", phy_bank, hw_bank);
    chk("R9 strobes", {phy_cs_n, phy_ras_n, phy_cas_n, phy_we_n}, 8'b01_10_11_00);
    chk("R9 enables", {phy_wrdata_en, phy_rddata_en}, 4'b01_10);
    chk("R9 wrdata", phy_wrdata, hw_wrdata);
    wr(32, 8'h0f);
    chk("R9 sw cmd blocked", {phy_cs_n, phy_ras_n, phy_cas_n, phy_we_n}, 8'b01_10_11_00);
    wr(64, 8'h21);
    strobe(1, 64'h5555_5555_5555_5555);
    rd_capture(1, cap); chk("R8 no capture in hw mode", cap, 64'h8899_aabb_ccdd_eefe);
    phy_rddata = {64'h0a0b_0c0d_0e0f_1011, 64'h2021_2223_2425_2627}; #1;
    chk("R9 rddata forward", hw_rddata, phy_rddata);
    wr(0, 1);
    chk("R3 cke low in hw mode", phy_cke, 0);
    chk("R9 still hw", phy_addr, hw_addr);

    // R10: unmapped space
    wr(0, 2);
    rd(4, b);   chk("R10 unmapped read", b, 0);
    rd(96, b);  chk("R10 unmapped block", b, 0);
    wr(5, 8'hff);
    wr(100, 8'hff);
    rd(0, b);   chk("R10 ctrl untouched", b, 2);
    wr(32 + 4, 8'h55);
    rd(32 + 4, b); chk("R10 phase hole", b, 0);
    rd(32 + 1, b); chk("R10 addr untouched", b, 8'ha5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule